// File: doc/BRIEF.md
# Opcode-in-Flags 32-bit ALU

This unit is the arithmetic and logic stage of a compact three-operand core. The instruction that triggers it does not say which operation to perform; the operation is read from the low byte of the core's flags register. Software writes that byte once, then issues any number of ALU instructions, and each one applies the same operation to a new pair of 32-bit operands until the byte is rewritten.

Each ALU strobe yields a registered 32-bit result one cycle later. It also yields a new flags word for write-back into the flags register. In that word the zero and negative bits are refreshed and every other bit, including the operation byte, is passed through. A separate move strobe adds the two operands no matter what the operation byte holds, and it leaves the flags untouched. A single-cycle valid pulse marks each new output.

Top module: `opsel_alu`

## Requirements
- R1: A cycle with `execute` or `moveAdd` high at a rising clock edge makes `result` and `flagsOut` take their new values at that edge, and `outValid` is high for exactly the following cycle.
- R2: With an `execute` strobe, `flagsIn[7:0]` selects the operation. The value 0 adds, 1 subtracts (`opA - opB`), 2 is bitwise AND, 3 is bitwise OR and 4 is bitwise XOR. Add and subtract wrap modulo 2^32.
- R3: Operation byte values 5, 6 and 7 shift `opA` by `opB[4:0]` places. Value 5 is a left shift, 6 is a logical right shift and 7 is an arithmetic right shift that copies bit 31.
- R4: Any operation byte value from 8 to 255 gives a result of 0.
- R5: After an `execute` strobe, bit 8 of `flagsOut` is 1 exactly when the new result is 0.
- R6: After an `execute` strobe, bit 9 of `flagsOut` equals bit 31 of the new result.
- R7: Every `flagsOut` bit other than 8 and 9 equals the same bit of `flagsIn` at the strobe. This includes the operation byte in bits 7:0.
- R8: A `moveAdd` strobe gives `opA + opB` whatever the operation byte holds, and `flagsOut` becomes `flagsIn` unchanged. When `moveAdd` and `execute` are both high, `moveAdd` wins.
- R9: In a cycle with no strobe, `result` and `flagsOut` keep their values and ignore the operand and flags inputs.
- R10: While `rstN` is low, `result`, `flagsOut` and `outValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| execute | input | 1 | ALU strobe: the operation is taken from the flags byte |
| moveAdd | input | 1 | Move strobe: adds the operands and leaves the flags alone |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, which is also the shift amount |
| flagsIn | input | 32 | Current flags register; bits 7:0 hold the operation |
| result | output | 32 | Registered result |
| flagsOut | output | 32 | Flags word for write-back |
| outValid | output | 1 | One-cycle pulse when a new result is present |

## Verification
The bench steps through all sixteen low operation byte values and a few high ones. For each it uses operand pairs chosen to tell the operations apart: zeros, all ones, the sign bit alone, the largest positive value, equal operands that make subtraction zero, and pseudo-random words. Shift amounts of 0, 1, 31 and values with bits set above bit 4 separate logical from arithmetic right shifts and show that the upper bits of the amount are ignored. Random upper flag bits show that the write-back preserves the bits it does not own. Idle cycles with changed inputs, and moves issued under every operation byte, show that the operation byte only matters on an ALU strobe.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SHL = 3'd5,
    OP_SHR = 3'd6,
    OP_SAR = 3'd7
  } aluOp_e;

  typedef struct packed {
    logic   capture;
    logic   setFlags;
    logic   opKnown;
    aluOp_e op;
  } ctrlStrobe_t;

endpackage

// File: rtl/opsel_alu_ctrl.sv
module opsel_alu_ctrl
  import opsel_alu_pkg::*;
#(
  parameter int OP_BITS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               execute,
  input  logic               moveAdd,
  input  logic [OP_BITS-1:0] opByte,
  output ctrlStrobe_t        strobe,
  output logic               validQ
);

  localparam int NUM_OPS = 8;

  always_comb begin
    strobe.capture  = execute | moveAdd;
    strobe.setFlags = execute & ~moveAdd;
    if (moveAdd) begin
      strobe.opKnown = 1'b1;
      strobe.op      = OP_ADD;
    end else begin
      strobe.opKnown = (int'(opByte) < NUM_OPS);
      strobe.op      = aluOp_e'(opByte[2:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= strobe.capture;
  end

  // R1: the valid pulse follows a strobe and never appears without one
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    (execute || moveAdd) |=> validQ);
  p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(execute || moveAdd) |=> !validQ);
  // R8: a move never refreshes the flags
  p_move_no_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    moveAdd |-> !strobe.setFlags);

endmodule

// File: rtl/opsel_alu_datapath.sv
module opsel_alu_datapath
  import opsel_alu_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int ZERO_BIT = 8,
  parameter int NEG_BIT  = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] flagsIn,
  output logic [WIDTH-1:0] resultQ,
  output logic [WIDTH-1:0] flagsQ
);

  localparam int SHIFT_BITS = $clog2(WIDTH);

  logic [SHIFT_BITS-1:0]   shAmt;
  logic signed [WIDTH-1:0] signedA;
  logic [WIDTH-1:0]        nextRes;
  logic [WIDTH-1:0]        nextFlags;

  assign shAmt   = opB[SHIFT_BITS-1:0];
  assign signedA = opA;

  always_comb begin
    nextRes = '0;
    if (strobe.opKnown) begin
      case (strobe.op)
        OP_ADD:  nextRes = opA + opB;
        OP_SUB:  nextRes = opA - opB;
        OP_AND:  nextRes = opA & opB;
        OP_OR:   nextRes = opA | opB;
        OP_XOR:  nextRes = opA ^ opB;
        OP_SHL:  nextRes = opA << shAmt;
        OP_SHR:  nextRes = opA >> shAmt;
        OP_SAR:  nextRes = WIDTH'(signedA >>> shAmt);
        default: nextRes = '0;
      endcase
    end
  end

  always_comb begin
    nextFlags = flagsIn;
    if (strobe.setFlags) begin
      nextFlags[ZERO_BIT] = (nextRes == '0);
      nextFlags[NEG_BIT]  = nextRes[WIDTH-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      flagsQ  <= '0;
    end else if (strobe.capture) begin
      resultQ <= nextRes;
      flagsQ  <= nextFlags;
    end
  end

  // R4: an unknown operation produces a zero result
  p_unknown_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.opKnown) |=> (resultQ == '0));
  // R5: the zero flag matches the stored result
  p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.setFlags) |=> (flagsQ[ZERO_BIT] == (resultQ == '0)));
  // R6: the negative flag matches the sign of the stored result
  p_neg_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.setFlags) |=> (flagsQ[NEG_BIT] == resultQ[WIDTH-1]));
  // R9: no strobe means no change
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(resultQ) && $stable(flagsQ)));

endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
  import opsel_alu_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int OP_BITS  = 8,
  parameter int ZERO_BIT = 8,
  parameter int NEG_BIT  = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             execute,
  input  logic             moveAdd,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] flagsIn,
  output logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] flagsOut,
  output logic             outValid
);

  ctrlStrobe_t strobe;

  opsel_alu_ctrl #(
    .OP_BITS (OP_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .execute (execute),
    .moveAdd (moveAdd),
    .opByte  (flagsIn[OP_BITS-1:0]),
    .strobe  (strobe),
    .validQ  (outValid)
  );

  opsel_alu_datapath #(
    .WIDTH    (WIDTH),
    .ZERO_BIT (ZERO_BIT),
    .NEG_BIT  (NEG_BIT)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .flagsIn (flagsIn),
    .resultQ (result),
    .flagsQ  (flagsOut)
  );

  // R7: the operation byte is written back unchanged
  p_opbyte_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (execute || moveAdd) |=> (flagsOut[OP_BITS-1:0] == $past(flagsIn[OP_BITS-1:0])));
  // R8: a move adds the operands and leaves the flags alone
  p_move_add_r8: assert property (@(posedge clk) disable iff (!rstN)
    moveAdd |=> ((result == $past(opA) + $past(opB)) && (flagsOut == $past(flagsIn))));

endmodule

// File: tb/opsel_alu_bench.sv
module opsel_alu_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        execute = 1'b0;
  logic        moveAdd = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] flagsIn = '0;
  logic [31:0] result;
  logic [31:0] flagsOut;
  logic        outValid;

  int checks = 0;
  int errors = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  opsel_alu u_opsel_alu (
    .clk(clk), .rstN(rstN), .execute(execute), .moveAdd(moveAdd),
    .opA(opA), .opB(opB), .flagsIn(flagsIn),
    .result(result), .flagsOut(flagsOut), .outValid(outValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  function automatic logic [31:0] expResult(input logic [7:0] op, input logic [31:0] a,
                                            input logic [31:0] b);
    logic signed [31:0] sa;
    sa = a;
    case (op)
      8'd0: return a + b;
      8'd1: return a - b;
      8'd2: return a & b;
      8'd3: return a | b;
      8'd4: return a ^ b;
      8'd5: return a << b[4:0];
      8'd6: return a >> b[4:0];
      8'd7: return 32'(sa >>> b[4:0]);
      default: return 32'd0;
    endcase
  endfunction

  // Issue one strobe, check the captured outputs, then one idle cycle.
  task automatic runOp(input logic [7:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic mv, input logic ex);
    logic [31:0] flg;
    logic [31:0] expR;
    logic [31:0] expF;
    flg = {nextRand()} & 32'hFFFF_FF00;
    flg[7:0] = op;
    @(negedge clk);
    opA = a; opB = b; flagsIn = flg; moveAdd = mv; execute = ex;
    @(negedge clk);
    execute = 1'b0; moveAdd = 1'b0;
    if (mv) begin
      expR = a + b;
      expF = flg;
    end else begin
      expR = expResult(op, a, b);
      expF = flg;
      expF[8] = (expR == 32'd0);
      expF[9] = expR[31];
    end
    check("R1 valid pulse", {31'd0, outValid}, 32'd1);
    if (mv) check("R8 move result", result, expR);
    else if (op < 8'd5) check("R2 result", result, expR);
    else if (op < 8'd8) check("R3 shift result", result, expR);
    else check("R4 unknown op result", result, expR);
    if (mv) check("R8 flags unchanged", flagsOut, expF);
    else begin
      check("R5 zero flag", {31'd0, flagsOut[8]}, {31'd0, expF[8]});
      check("R6 negative flag", {31'd0, flagsOut[9]}, {31'd0, expF[9]});
      check("R7 other flag bits", flagsOut & 32'hFFFF_FCFF, expF & 32'hFFFF_FCFF);
    end
    // idle cycle with disturbed inputs
    opA = ~a; opB = nextRand(); flagsIn = nextRand();
    @(negedge clk);
    check("R1 valid single cycle", {31'd0, outValid}, 32'd0);
    check("R9 result held", result, expR);
    check("R9 flags held", flagsOut, expF);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stimulus
    logic [31:0] pa [12];
    logic [31:0] pb [12];
    pa[0] = 32'd0;          pb[0] = 32'd0;
    pa[1] = 32'hFFFF_FFFF;  pb[1] = 32'd1;
    pa[2] = 32'h8000_0000;  pb[2] = 32'd31;
    pa[3] = 32'h7FFF_FFFF;  pb[3] = 32'h8000_0001;
    pa[4] = 32'h1234_5678;  pb[4] = 32'h1234_5678;
    pa[5] = 32'hF0F0_00FF;  pb[5] = 32'h0000_0024;
    pa[6] = 32'h8765_4321;  pb[6] = 32'hFFFF_FFE1;
    pa[7] = 32'd1;          pb[7] = 32'd0;
    for (int k = 8; k < 12; k++) begin
      pa[k] = nextRand();
      pb[k] = nextRand();
    end
    repeat (3) @(negedge clk);
    // R10: reset values
    check("R10 reset result", result, 32'd0);
    check("R10 reset flags", flagsOut, 32'd0);
    check("R10 reset valid", {31'd0, outValid}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 12; k++) runOp(8'(op), pa[k], pb[k], 1'b0, 1'b1);
    end
    for (int k = 0; k < 12; k++) begin
      runOp(8'hFF, pa[k], pb[k], 1'b0, 1'b1);
      runOp(8'h85, pa[k], pb[k], 1'b0, 1'b1);
    end
    // R8: move under every operation byte, alone and together with execute
    for (int op = 0; op < 10; op++) begin
      runOp(8'(op), pa[op], pb[op], 1'b1, 1'b0);
      runOp(8'(op), pa[op + 2], pb[op], 1'b1, 1'b1);
    end
    // R1: back-to-back strobes under one operation byte
    @(negedge clk);
    flagsIn = 32'h0000_0001; opA = 32'd10; opB = 32'd3; execute = 1'b1;
    @(negedge clk);
    check("R2 back-to-back first", result, 32'd7);
    check("R1 valid first", {31'd0, outValid}, 32'd1);
    opA = 32'd3; opB = 32'd10;
    @(negedge clk);
    execute = 1'b0;
    check("R2 back-to-back second", result, 32'hFFFF_FFF9);
    check("R6 back-to-back negative", {31'd0, flagsOut[9]}, 32'd1);
    check("R1 valid second", {31'd0, outValid}, 32'd1);
    @(negedge clk);
    check("R1 valid drops", {31'd0, outValid}, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule